// File: doc/BRIEF.md
# Programmable-Ratio Cascaded Integrator-Comb Decimator

This block lowers the sample rate of a real-valued, signed sample stream by an integer ratio that can be changed while it runs. It serves as the first, narrowband stage of a receive chain after the mixer. A cascade of integrators accumulates every accepted input sample at the full rate. A counter then picks every R-th integrator value into a holding register, and a cascade of comb (first-difference) stages works on those picked values at the reduced rate. The result is shifted down by the bit growth of the current ratio, so the DC gain stays near one, and leaves the block with a one-cycle valid pulse.

The datapath uses only adders, subtractors and registers. The internal accumulators are wide enough for the largest ratio at the full stage count. Integrators may wrap in two's complement, and the combs undo the wrap. A droop-correcting filter is expected downstream. The ratio is applied through a clamp. Writing a new value restarts the decimation phase.

Top module: `cic_decimator`

## Requirements
- R1: While and right after reset, `outValid` is 0 and `outData` is 0.
- R2: For a ratio that is a power of two and a constant input x held long enough to settle, every output equals x exactly. This holds for positive and negative x.
- R3: The output is the comb result arithmetically shifted right by STAGES*ceil(log2 R) bits and truncated to OUT_W bits. With 5 stages, DC input 4096 at R=3 gives 972, and DC input -32768 at R=5 gives -3125.
- R4: At the largest ratio (4096) with 5 stages, a DC input of 20000 gives 20000 with no overflow.
- R5: Exactly one output pulse is produced per R accepted inputs. Cycles with `inValid` low are not counted, and an incomplete group of inputs produces no pulse.
- R6: `outValid` is high for one cycle at a time. With `inValid` held high, consecutive pulses are exactly R cycles apart.
- R7: A `ratio` value below 2 acts as 2, and a value above 4096 acts as 4096.
- R8: A change of `ratio` clears the decimation count. A partial group collected before the change is dropped. A sample accepted in the same cycle as the change is the first of the new group.
- R9: `outData` keeps its value in every cycle in which `outValid` is low.
- R10: `outValid` rises after the second rising edge that follows the edge accepting the R-th input of a group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input sample strobe |
| inData | input | IN_W (16) | Signed input sample |
| ratio | input | RATIO_W (13) | Requested decimation ratio, clamped to 2..RMAX |
| outValid | output | 1 | One-cycle strobe per decimated output |
| outData | output | OUT_W (16) | Signed, scaled decimated sample |

## Verification
The bench runs the maximum ratio with a large DC level. A design whose accumulators are too narrow wraps there, and the wrap shows as a wrong settled value. Two non-power-of-two ratios check the scaling. A wrong shift count or a logical shift in place of an arithmetic one gives a different settled value, and the negative case also catches a lost sign. Gapped valid patterns, partial groups and a ratio change in the middle of a group look for a counter that counts idle cycles or keeps a stale phase, which would show as an extra or missing pulse. Out-of-range ratios and cycle-exact latency and pulse spacing are measured at the ports.

// File: rtl/cic_pkg.sv
package cic_pkg;

  // Strobes passed from the control to the datapath sections.
  typedef struct packed {
    logic integ;     // accumulate one input sample
    logic capture;   // take integrator result into the holding register
    logic combStep;  // advance the comb stages once
    logic outLoad;   // register the scaled result and pulse valid
  } cicStrobes_t;

  // Smallest k with 2**k >= v, for v >= 1.
  function automatic logic [4:0] ceilLog2(input logic [15:0] v);
    logic [4:0] r;
    r = 5'd16;
    for (int k = 15; k >= 0; k--) begin
      if ((32'd1 << k) >= {16'd0, v}) r = 5'(k);
    end
    return r;
  endfunction

endpackage

// File: rtl/cic_ctrl.sv
module cic_ctrl
  import cic_pkg::*;
#(
  parameter int STAGES  = 5,
  parameter int RMAX    = 4096,
  parameter int RATIO_W = 13,
  parameter int SHIFT_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [RATIO_W-1:0] ratio,
  output cicStrobes_t        strobes,
  output logic [RATIO_W-1:0] curRatio,
  output logic [SHIFT_W-1:0] shiftAmt
);

  localparam logic [RATIO_W-1:0] R_LO = RATIO_W'(2);
  localparam logic [RATIO_W-1:0] R_HI = RATIO_W'(RMAX);

  logic [RATIO_W-1:0] ratioSel;
  logic [RATIO_W-1:0] ratioQ;
  logic [RATIO_W-1:0] cnt;
  logic               ratioChange;
  logic               lastOfGroup;
  logic               captureQ;
  logic               combStepQ;

  always_comb begin
    if (ratio < R_LO)      ratioSel = R_LO;
    else if (ratio > R_HI) ratioSel = R_HI;
    else                   ratioSel = ratio;
  end

  assign ratioChange = (ratioSel != ratioQ);
  assign lastOfGroup = inValid && !ratioChange && (cnt == ratioQ - RATIO_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ratioQ <= R_LO;
      cnt    <= '0;
    end else if (ratioChange) begin
      ratioQ <= ratioSel;
      cnt    <= inValid ? RATIO_W'(1) : '0;
    end else if (inValid) begin
      if (lastOfGroup) cnt <= '0;
      else             cnt <= cnt + RATIO_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      captureQ  <= 1'b0;
      combStepQ <= 1'b0;
    end else begin
      captureQ  <= lastOfGroup;
      combStepQ <= captureQ;
    end
  end

  always_comb begin
    int growth;
    growth   = STAGES * int'(ceilLog2(16'(ratioQ)));
    shiftAmt = SHIFT_W'(growth);
  end

  assign strobes.integ    = inValid;
  assign strobes.capture  = lastOfGroup;
  assign strobes.combStep = captureQ;
  assign strobes.outLoad  = combStepQ;
  assign curRatio         = ratioQ;

endmodule

// File: rtl/cic_integrators.sv
module cic_integrators
  import cic_pkg::*;
#(
  parameter int STAGES = 5,
  parameter int IN_W   = 16,
  parameter int ACC_W  = 76
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  cicStrobes_t             strobes,
  input  logic signed [IN_W-1:0]  inData,
  output logic signed [ACC_W-1:0] integOut
);

  logic signed [ACC_W-1:0] acc [STAGES];
  logic signed [ACC_W-1:0] src [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign src[s] = {{(ACC_W-IN_W){inData[IN_W-1]}}, inData};
    end else begin : g_next
      assign src[s] = acc[s-1];
    end

    // Wraparound is intended; the combs cancel it.
    always_ff @(posedge clk) begin
      if (!rstN)              acc[s] <= '0;
      else if (strobes.integ) acc[s] <= acc[s] + src[s];
    end
  end

  assign integOut = acc[STAGES-1];

endmodule

// File: rtl/cic_combs.sv
module cic_combs
  import cic_pkg::*;
#(
  parameter int STAGES  = 5,
  parameter int ACC_W   = 76,
  parameter int OUT_W   = 16,
  parameter int SHIFT_W = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  cicStrobes_t             strobes,
  input  logic signed [ACC_W-1:0] integOut,
  input  logic [SHIFT_W-1:0]      shiftAmt,
  output logic                    outValid,
  output logic signed [OUT_W-1:0] outData
);

  logic signed [ACC_W-1:0] holdQ;
  logic signed [ACC_W-1:0] stageIn [STAGES+1];
  logic signed [ACC_W-1:0] dly     [STAGES];
  logic signed [ACC_W-1:0] combQ;
  logic signed [OUT_W-1:0] scaled;

  // Decimating holding register.
  always_ff @(posedge clk) begin
    if (!rstN)                holdQ <= '0;
    else if (strobes.capture) holdQ <= integOut;
  end

  assign stageIn[0] = holdQ;

  for (genvar s = 0; s < STAGES; s++) begin : g_comb
    assign stageIn[s+1] = stageIn[s] - dly[s];

    always_ff @(posedge clk) begin
      if (!rstN)                 dly[s] <= '0;
      else if (strobes.combStep) dly[s] <= stageIn[s];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 combQ <= '0;
    else if (strobes.combStep) combQ <= stageIn[STAGES];
  end

  assign scaled = OUT_W'(combQ >>> shiftAmt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= strobes.outLoad;
      if (strobes.outLoad) outData <= scaled;
    end
  end

endmodule

// File: rtl/cic_decimator.sv
module cic_decimator
  import cic_pkg::*;
#(
  parameter int STAGES = 5,
  parameter int IN_W   = 16,
  parameter int OUT_W  = 16,
  parameter int RMAX   = 4096,
  localparam int LOG_RMAX = $clog2(RMAX),
  localparam int RATIO_W  = LOG_RMAX + 1,
  localparam int ACC_W    = IN_W + STAGES * LOG_RMAX,
  localparam int SHIFT_W  = $clog2(STAGES * LOG_RMAX + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic signed [IN_W-1:0]  inData,
  input  logic [RATIO_W-1:0]      ratio,
  output logic                    outValid,
  output logic signed [OUT_W-1:0] outData
);

  cicStrobes_t             strobes;
  logic [RATIO_W-1:0]      curRatio;
  logic [SHIFT_W-1:0]      shiftAmt;
  logic signed [ACC_W-1:0] integOut;

  cic_ctrl #(
    .STAGES(STAGES), .RMAX(RMAX), .RATIO_W(RATIO_W), .SHIFT_W(SHIFT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .ratio(ratio),
    .strobes(strobes), .curRatio(curRatio), .shiftAmt(shiftAmt)
  );

  cic_integrators #(
    .STAGES(STAGES), .IN_W(IN_W), .ACC_W(ACC_W)
  ) u_integ (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inData(inData),
    .integOut(integOut)
  );

  cic_combs #(
    .STAGES(STAGES), .ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT_W(SHIFT_W)
  ) u_comb (
    .clk(clk), .rstN(rstN), .strobes(strobes), .integOut(integOut),
    .shiftAmt(shiftAmt), .outValid(outValid), .outData(outData)
  );

endmodule

// File: rtl/cic_decimator_chk.sv
module cic_decimator_chk #(
  parameter int OUT_W   = 16,
  parameter int RATIO_W = 13,
  parameter int RMAX    = 4096
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             outValid,
  input logic [OUT_W-1:0] outData,
  input logic [RATIO_W-1:0] curRatio
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> !outValid && outData == '0);

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R9
  hold_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outData));

  // R10
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 3));

  // R7
  ratio_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    curRatio >= RATIO_W'(2) && curRatio <= RATIO_W'(RMAX));

endmodule

bind cic_decimator cic_decimator_chk #(
  .OUT_W(OUT_W), .RATIO_W(RATIO_W), .RMAX(RMAX)
) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .outValid(outValid),
  .outData(outData), .curRatio(curRatio)
);

// File: tb/tb_cic_decimator.sv
module tb_cic_decimator;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               inValid = 1'b0;
  logic signed [15:0] inData = '0;
  logic [12:0]        ratio = 13'd2;
  logic               outValid;
  logic signed [15:0] outData;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int cycle = 0;
  int lastPulseCycle = 0;
  int interval = 0;
  int lastOut = 0;
  int prevOut = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cic_decimator dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .ratio(ratio), .outValid(outValid), .outData(outData)
  );

  // Monitor at the rising edge sees the values held before the edge.
  always @(posedge clk) begin
    cycle++;
    if (outValid) begin
      pulses++;
      interval = cycle - lastPulseCycle;
      lastPulseCycle = cycle;
      prevOut = lastOut;
      lastOut = int'(outData);
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    inValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic feed(input int n, input int x, input int gap);
    for (int i = 0; i < n; i++) begin
      inValid = 1'b1;
      inData  = 16'(x);
      @(negedge clk);
      if (gap > 0) idle(gap);
    end
    inValid = 1'b0;
  endtask

  task automatic setRatio(input int r);
    idle(6);
    ratio = 13'(r);
    idle(2);
  endtask

  task automatic testReset();
    chk("R1 outValid in reset", outValid, 0);
    chk("R1 outData in reset", outData, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 outValid after reset", outValid, 0);
    chk("R1 outData after reset", outData, 0);
  endtask

  task automatic dcTest(input string tag, input int r, input int x, input int exp);
    setRatio(r);
    feed(12 * r, x, 0);
    idle(6);
    chk({tag, " last output"}, lastOut, exp);
    chk({tag, " previous output"}, prevOut, exp);
  endtask

  task automatic spacingTest(input string tag, input int r, input int exp);
    setRatio(r);
    feed(4 * exp + 8, 100, 0);
    chk(tag, interval, exp);
  endtask

  task automatic gappedTest();
    int base;
    setRatio(5);
    base = pulses;
    feed(20, 300, 2);
    idle(10);
    chk("R5 pulses for 20 gapped inputs at R=5", pulses - base, 4);
    base = pulses;
    feed(3, 300, 1);
    idle(10);
    chk("R5 partial group gives no pulse", pulses - base, 0);
  endtask

  task automatic restartTest();
    int base;
    setRatio(8);
    feed(3, 50, 0);
    ratio = 13'd6;
    idle(2);
    base = pulses;
    feed(12, 50, 1);
    idle(10);
    chk("R8 pulses after ratio change", pulses - base, 2);
    // Sample in the change cycle counts as first of the group.
    setRatio(7);
    base = pulses;
    ratio = 13'd4;
    feed(4, 50, 0);
    idle(10);
    chk("R8 change-cycle sample starts group", pulses - base, 1);
  endtask

  task automatic latencyTest();
    logic signed [15:0] held;
    setRatio(2);
    feed(2, 700, 0);
    chk("R10 low one edge after", outValid, 0);
    @(negedge clk);
    chk("R10 low two edges... edge+1", outValid, 0);
    @(negedge clk);
    chk("R10 high after second edge", outValid, 1);
    held = outData;
    @(negedge clk);
    chk("R6 pulse lasts one cycle", outValid, 0);
    idle(5);
    chk("R9 outData held while idle", outData, held);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired after %0d cycles expected earlier finish", WATCHDOG);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    idle(4);
    testReset();
    dcTest("R2 dc positive R=4", 4, 1000, 1000);
    dcTest("R2 dc negative R=16", 16, -1234, -1234);
    dcTest("R3 scaling R=3", 3, 4096, 972);
    dcTest("R3 scaling negative R=5", 5, -32768, -3125);
    dcTest("R4 max ratio", 4096, 20000, 20000);
    spacingTest("R6 spacing R=7", 7, 7);
    spacingTest("R7 ratio 0 acts as 2", 0, 2);
    spacingTest("R7 ratio 5000 acts as 4096", 5000, 4096);
    gappedTest();
    restartTest();
    latencyTest();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule